// File: doc/BRIEF.md
# Contiguous Heap Bank Allocator

This block keeps the bookkeeping for a pool of equally sized memory banks that a processor can claim and release at run time. A program writes a byte count to the allocation port; the block searches for enough adjacent free banks, claims them as one allocation, and returns the address of the first byte. A program writes an allocation's base address to the release port; the block checks that the address really opens a live allocation and then returns every bank of it to the pool.

The search is first-fit. It starts at the lowest bank and looks at one bank per clock. While it runs, `busy` is high and new commands are ignored. Every accepted command ends with a one-cycle `done` pulse. `result` and `error` are valid with that pulse and hold until the next one. The bank contents and the byte access path are not part of this block.

Top module: `heap_bank_alloc`

## Requirements
- R1: After reset, `busy`, `done` and `error` are 0, `result` is 0, and every bank is free, so the first allocation returns the pool base 0xB700.
- R2: A request for `s` bytes claims ceil(s/64) adjacent banks. Bank k is at address 0xB700 + 64·k. On success `result` is that base and `error` is 0.
- R3: The search is first-fit. The claimed run is the lowest-numbered run of free banks that is long enough, and a shorter gap below it is skipped.
- R4: A bank that is owned is never claimed again until it has been freed.
- R5: When no run of free banks is long enough, the request completes with `error`=1 and `result`=0, and no bank changes state.
- R6: A request of 0 bytes, or of more than 8192 bytes, fails at once. `done` comes one cycle after acceptance with `error`=1, `result`=0, and no search takes place.
- R7: A release write (port 0x834) whose data is the base of a live allocation frees all banks of that allocation. It completes one cycle after acceptance with `error`=0 and `result`=0.
- R8: A release write whose address is not the start of a live allocation sets `error`=1 and changes nothing. This covers an address inside an allocation, a free bank, a misaligned address and an address outside the pool.
- R9: `busy` is high from the cycle after an allocation is accepted until its `done`. `done` is a single-cycle pulse and is never high together with `busy`.
- R10: A write to any address other than 0x830 (allocate) or 0x834 (release), or any write made while `busy` is high, produces no `done` and changes no bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command write strobe |
| req_addr | input | 12 | Port address: 0x830 allocate, 0x834 release |
| req_data | input | 32 | Byte count (allocate) or base address (release) |
| busy | output | 1 | Allocation search in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last completed command failed |
| result | output | 32 | Base address of the last allocation, 0 on failure or release |

## Verification
On every cycle, the assertions check the completion handshake (single `done` pulse, never together with `busy`). They check that a bank newly becomes owned only at a successful completion, that failed commands leave the ownership vector untouched, and that every address returned is aligned and inside the pool. First-fit placement, the rounding of byte counts to whole banks, and the reuse of a freed gap can only be shown by the bench's scenarios. So can the rejection of releases that do not point at an allocation start, and the fit of a run that ends exactly at the last bank. Each of these depends on a history of earlier commands.

// File: rtl/heap_bank_alloc.sv
module heap_bank_alloc #(
  parameter int NUM_BANKS = 128,
  parameter int BANK_BYTES = 64,
  parameter logic [31:0] BASE_ADDR = 32'h0000_B700,
  parameter logic [11:0] ALLOC_PORT = 12'h830,
  parameter logic [11:0] FREE_PORT = 12'h834
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [11:0] req_addr,
  input  logic [31:0] req_data,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic [31:0] result
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int LEN_W = BANK_W + 1;
  localparam int OFF_W = $clog2(BANK_BYTES);
  localparam logic [31:0] TOTAL = 32'(NUM_BANKS * BANK_BYTES);

  logic [NUM_BANKS-1:0] owned;
  logic [NUM_BANKS-1:0] first;
  logic [LEN_W-1:0]     span [NUM_BANKS];

  logic [BANK_W-1:0] scan_idx, run_start;
  logic [LEN_W-1:0]  run_len, need;

  wire accept    = req_valid && !busy;
  wire is_alloc  = accept && req_addr == ALLOC_PORT;
  wire is_free   = accept && req_addr == FREE_PORT;
  wire size_bad  = req_data == 32'd0 || req_data > TOTAL;
  wire [31:0] size_up = (req_data + 32'(BANK_BYTES - 1)) >> OFF_W;

  wire [31:0]       f_off = req_data - BASE_ADDR;
  wire [BANK_W-1:0] f_idx = f_off[OFF_W +: BANK_W];
  wire f_ok = req_data >= BASE_ADDR && f_off < TOTAL &&
              f_off[OFF_W-1:0] == '0 && first[f_idx];

  wire              cur_free  = !owned[scan_idx];
  wire [BANK_W-1:0] hit_start = (run_len == '0) ? scan_idx : run_start;
  wire              hit       = busy && cur_free && (run_len + 1'b1 == need);
  wire              last_bank = scan_idx == BANK_W'(NUM_BANKS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owned     <= '0;
      first     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      result    <= '0;
      scan_idx  <= '0;
      run_start <= '0;
      run_len   <= '0;
      need      <= '0;
      for (int k = 0; k < NUM_BANKS; k++) span[k] <= '0;
    end else begin
      done <= 1'b0;
      if (is_alloc) begin
        if (size_bad) begin
          done   <= 1'b1;
          error  <= 1'b1;
          result <= '0;
        end else begin
          busy      <= 1'b1;
          need      <= size_up[LEN_W-1:0];
          scan_idx  <= '0;
          run_start <= '0;
          run_len   <= '0;
        end
      end else if (is_free) begin
        done   <= 1'b1;
        error  <= !f_ok;
        result <= '0;
        if (f_ok) begin
          first[f_idx] <= 1'b0;
          for (int k = 0; k < NUM_BANKS; k++)
            if (k >= int'(f_idx) && k < int'(f_idx) + int'(span[f_idx]))
              owned[k] <= 1'b0;
        end
      end else if (busy) begin
        if (hit) begin
          busy             <= 1'b0;
          done             <= 1'b1;
          error            <= 1'b0;
          result           <= BASE_ADDR + (32'(hit_start) << OFF_W);
          first[hit_start] <= 1'b1;
          span[hit_start]  <= need;
          for (int k = 0; k < NUM_BANKS; k++)
            if (k >= int'(hit_start) && k < int'(hit_start) + int'(need))
              owned[k] <= 1'b1;
        end else if (last_bank) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          error  <= 1'b1;
          result <= '0;
        end else begin
          scan_idx <= scan_idx + 1'b1;
          if (cur_free) begin
            run_len <= run_len + 1'b1;
            if (run_len == '0) run_start <= scan_idx;
          end else begin
            run_len <= '0;
          end
        end
      end
    end
  end
endmodule

module heap_bank_alloc_chk #(
  parameter int NUM_BANKS = 128,
  parameter int BANK_BYTES = 64,
  parameter logic [31:0] BASE_ADDR = 32'h0000_B700,
  parameter logic [11:0] ALLOC_PORT = 12'h830
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [11:0]          req_addr,
  input logic [31:0]          req_data,
  input logic                 busy,
  input logic                 done,
  input logic                 error,
  input logic [31:0]          result,
  input logic [NUM_BANKS-1:0] owned
);
  localparam logic [31:0] TOTAL = 32'(NUM_BANKS * BANK_BYTES);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
  assert_search_ends_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_fail_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && error) |-> result == 32'd0);
  assert_fail_keeps_banks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && error) |-> owned == $past(owned));
  assert_claim_only_on_success_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(owned & ~$past(owned))) |-> (done && !error && result != 32'd0));
  assert_addr_in_pool_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result != 32'd0) |->
      (!error && result >= BASE_ADDR && result - BASE_ADDR < TOTAL &&
       (result - BASE_ADDR) % BANK_BYTES == 0));
  assert_bad_size_fast_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_addr == ALLOC_PORT &&
     (req_data == 32'd0 || req_data > TOTAL)) |=> (done && error && !busy));
endmodule

bind heap_bank_alloc heap_bank_alloc_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES),
  .BASE_ADDR(BASE_ADDR), .ALLOC_PORT(ALLOC_PORT)
) i_heap_bank_alloc_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_data(req_data), .busy(busy), .done(done), .error(error),
  .result(result), .owned(owned)
);

// File: tb/test_heap_bank_alloc.sv
module test_heap_bank_alloc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic busy, done, error;
  logic [31:0] result;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [31:0] B = 32'h0000_B700;

  always #2 clk = ~clk;

  heap_bank_alloc i_heap_bank_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .busy(busy), .done(done), .error(error), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [11:0] a, input logic [31:0] d, input string tag,
                     input logic [31:0] exp_res, input bit exp_err, input bit search,
                     output int cyc);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    if (search) chk(busy === 1'b1 && done === 1'b0, {tag, " R9 busy during search"}, {31'd0, busy}, 32'd1);
    while (done !== 1'b1 && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    chk(done === 1'b1, {tag, " done seen"}, {31'd0, done}, 32'd1);
    chk(result === exp_res, {tag, " result"}, result, exp_res);
    chk(error === exp_err, {tag, " error"}, {31'd0, error}, {31'd0, exp_err});
    chk(busy === 1'b0, {tag, " R9 idle at done"}, {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk(done === 1'b0, {tag, " R9 single pulse"}, {31'd0, done}, 32'd0);
  endtask

  task automatic alloc(input logic [31:0] sz, input logic [31:0] exp_res, input bit exp_err, input string tag);
    int c;
    cmd(12'h830, sz, tag, exp_res, exp_err, 1'b1, c);
  endtask

  task automatic release_at(input logic [31:0] a, input bit exp_err, input string tag);
    int c;
    cmd(12'h834, a, tag, 32'd0, exp_err, 1'b0, c);
    chk(c == 1, {tag, " release latency"}, c, 32'd1);
  endtask

  task automatic t_reset;
    chk(busy === 1'b0 && done === 1'b0 && error === 1'b0, "R1 reset flags",
        {29'd0, busy, done, error}, 32'd0);
    chk(result === 32'd0, "R1 reset result", result, 32'd0);
  endtask

  task automatic t_rounding;
    alloc(32'd64, B, 1'b0, "R1 R2 first 64B");
    alloc(32'd65, B + 32'h40, 1'b0, "R2 65B two banks");
    alloc(32'd1, B + 32'hC0, 1'b0, "R2 1B after two-bank run");
  endtask

  task automatic t_reuse;
    release_at(B + 32'h40, 1'b0, "R7 free two-bank alloc");
    alloc(32'd128, B + 32'h40, 1'b0, "R7 freed gap reused whole");
    release_at(B + 32'h40, 1'b0, "R7 free again");
    alloc(32'd192, B + 32'h100, 1'b0, "R3 skip short gap");
    alloc(32'd100, B + 32'h40, 1'b0, "R3 first fit fills gap");
  endtask

  task automatic t_bad_free;
    release_at(B + 32'h80, 1'b1, "R8 inside allocation");
    release_at(B + 32'd64 * 50, 1'b1, "R8 free bank");
    release_at(B + 32'd1, 1'b1, "R8 misaligned");
    release_at(32'h0000_1000, 1'b1, "R8 below pool");
    release_at(B + 32'd8192, 1'b1, "R8 above pool");
  endtask

  task automatic t_ignored;
    bit seen = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 12'h838; req_data = 32'd64;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (done === 1'b1 || busy === 1'b1) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, "R10 other port no response", {31'd0, seen}, 32'd0);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 12'h830; req_data = 32'd64;
    @(negedge clk);
    req_addr = 12'h830; req_data = 32'd8000;
    @(negedge clk);
    req_valid = 1'b0;
    while (done !== 1'b1) @(negedge clk);
    chk(result === B + 32'd64 * 7 && error === 1'b0, "R10 busy write dropped", result, B + 32'd64 * 7);
    @(negedge clk);
  endtask

  task automatic t_bad_size;
    int c;
    cmd(12'h830, 32'd0, "R6 zero size", 32'd0, 1'b1, 1'b0, c);
    chk(c == 1, "R6 zero size latency", c, 32'd1);
    cmd(12'h830, 32'd8193, "R6 oversize", 32'd0, 1'b1, 1'b0, c);
    chk(c == 1, "R6 oversize latency", c, 32'd1);
  endtask

  task automatic t_full;
    alloc(32'd7681, 32'd0, 1'b1, "R5 no run long enough");
    alloc(32'd7680, B + 32'd64 * 8, 1'b0, "R4 R5 exact fit to last bank");
    alloc(32'd1, 32'd0, 1'b1, "R4 pool full");
    release_at(B, 1'b0, "R7 free bank 0");
    alloc(32'd1, B, 1'b0, "R4 freed bank reissued");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rounding();
    t_reuse();
    t_bad_free();
    t_ignored();
    t_bad_size();
    t_full();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule